// File: doc/BRIEF.md
# Input Word Order Converter for a Hash Engine

This block sits between the write port of a hash engine and its message buffer. Every transfer carries one 32-bit word holding little-endian data. The block rearranges that word into the big-endian order that SHA-family compression expects, and hands it on one clock later with a valid/ready handshake. It does no padding, no length counting and no hashing.

The caller chooses one of four input representations through a 2-bit format control:

- whole 32-bit words, which pass through unchanged;
- 16-bit half-words, whose two halves are exchanged;
- bytes, whose order is reversed;
- bit strings, whose 32 bits are reversed end to end.

The format is captured when a message begins, which the caller signals with a pulse on `msg_start`. The format then stays fixed until the next such pulse, even if the control input moves during the message.

Top module: `wordswap_in`

## Requirements
- R1: While and right after reset, `out_valid` is 0 and `in_ready` is 1. The captured format resets to 00 (word).
- R2: Format 00 (word): the output word equals the input word.
- R3: Format 01 (half-word): output[31:16] = input[15:0] and output[15:0] = input[31:16].
- R4: Format 10 (byte): output byte k (bits 8k+7:8k) equals input byte 3-k, for k = 0..3.
- R5: Format 11 (bit string): output bit i equals input bit 31-i, for i = 0..31.
- R6: `fmt_sel` is captured on a cycle with `msg_start` = 1. A word accepted in that same cycle already uses the newly captured format.
- R7: A change of `fmt_sel` without `msg_start` has no effect. Later words keep the format captured at the last start.
- R8: A word accepted at a rising edge (`in_valid` and `in_ready` both 1) is presented on `out_data` with `out_valid` = 1 directly after that edge.
- R9: While `out_valid` = 1 and `out_ready` = 0, `out_data` and `out_valid` hold their values and `in_ready` is 0.
- R10: With `out_ready` held at 1, `in_ready` stays 1, and one word per cycle is accepted with no bubbles.
- R11: Before any `msg_start` after reset, words are handled as format 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| msg_start | input | 1 | Start-of-message pulse; captures `fmt_sel` |
| fmt_sel | input | 2 | Format: 00 word, 01 half-word, 10 byte, 11 bit |
| in_valid | input | 1 | Input word present |
| in_data | input | 32 | Little-endian input word |
| in_ready | output | 1 | Block can take a word this cycle |
| out_valid | output | 1 | Output word present |
| out_data | output | 32 | Reordered big-endian word |
| out_ready | input | 1 | Consumer takes the output word |

## Verification
Each word is due on the output one edge after the edge that accepts it. A capture of the format takes effect in the same cycle as the accepting edge.

The driver records each accepted word together with its expected reordering, computed in the bench by explicit bit, byte and half-word loops. It only records a word when `in_ready` is seen high at the falling edge before the accepting edge. The monitor compares every word at the falling edge before the edge that consumes it, and it also confirms that a stalled word stays unchanged across cycles.

With no back-pressure, the driver additionally checks `out_valid` and `out_data` just after the accepting edge. This pins the latency to exactly one cycle and the rate to one word per cycle.

// File: rtl/wordswap_in.sv
module wordswap_in #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         msg_start,
  input  logic [1:0]   fmt_sel,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);
  localparam int HW = W / 2;
  localparam int NB = W / 8;

  logic [1:0]   fmt_q;
  logic [1:0]   fmt_eff;
  logic [W-1:0] half_sw, byte_sw, bit_sw, swapped;
  logic         take;

  assign fmt_eff  = msg_start ? fmt_sel : fmt_q;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign half_sw  = {in_data[HW-1:0], in_data[W-1:HW]};

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign byte_sw[8*b +: 8] = in_data[8*(NB-1-b) +: 8];
  end
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_sw[i] = in_data[W-1-i];
  end

  always_comb begin
    case (fmt_eff)
      2'b01:   swapped = half_sw;
      2'b10:   swapped = byte_sw;
      2'b11:   swapped = bit_sw;
      default: swapped = in_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fmt_q <= 2'b00;
    else if (msg_start) fmt_q <= fmt_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= swapped;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r6_capture_fmt: assert property (@(posedge clk) disable iff (!rst_n)
    msg_start |=> fmt_q == $past(fmt_sel));
  a_r7_fmt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_start |=> $stable(fmt_q));
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  a_r9_stall_in: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  a_r5_bit_rev: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && fmt_eff == 2'b11 |=> out_data == {<<{$past(in_data)}});
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> !out_valid && in_ready);
endmodule

// File: tb/wordswap_in_tb.sv
module wordswap_in_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        msg_start = 0;
  logic [1:0]  fmt_sel = 0;
  logic        in_valid = 0;
  logic [31:0] in_data = 0;
  logic        in_ready, out_valid, out_ready;
  logic [31:0] out_data;

  int n_chk = 0, n_fail = 0;
  bit bp_en = 0;
  bit done = 0;
  logic [1:0] model_fmt = 2'b00;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  wordswap_in u_dut (
    .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .fmt_sel(fmt_sel),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready));

  function automatic logic [31:0] ref_swap(logic [31:0] d, logic [1:0] m);
    logic [31:0] r;
    r = d;
    if (m == 2'b01) r = {d[15:0], d[31:16]};
    else if (m == 2'b10)
      for (int k = 0; k < 4; k++) r[8*k +: 8] = d[8*(3-k) +: 8];
    else if (m == 2'b11)
      for (int i = 0; i < 32; i++) r[i] = d[31-i];
    return r;
  endfunction

  function automatic string mode_tag(logic [1:0] m);
    case (m)
      2'b01: return "R3";
      2'b10: return "R4";
      2'b11: return "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    out_ready = bp_en ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  // scoreboard monitor
  logic [31:0] prev_data;
  bit          prev_stall = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(out_valid && out_data == prev_data, "R9 hold", out_data, prev_data);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(0, "R8 unexpected word", out_data, 32'h0);
        else begin
          string t;
          logic [31:0] e;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_data == e, t, out_data, e);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  // called at posedge+#1
  task automatic send(logic [31:0] d, bit st, logic [1:0] f, string tag);
    bit acc;
    int tries;
    logic [1:0] m;
    m = st ? f : model_fmt;
    if (st) model_fmt = f;
    in_valid = 1; in_data = d; msg_start = st; fmt_sel = f;
    tries = 0;
    do begin
      @(negedge clk);
      acc = in_ready;
      tries++;
      if (acc) begin
        exp_q.push_back(ref_swap(d, m));
        tag_q.push_back(tag == "" ? mode_tag(m) : tag);
      end
      @(posedge clk); #1;
    end while (!acc);
    in_valid = 0; msg_start = 0;
    if (!bp_en) begin
      check(tries == 1, "R10 no bubble", 32'(tries), 32'd1);
      check(out_valid && out_data == ref_swap(d, m), "R8 latency", out_data, ref_swap(d, m));
    end
  endtask

  initial begin
    #40000;
    check(0, "watchdog", 0, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    out_ready = 1;
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready, "R1 reset", {30'b0, out_valid, in_ready}, 32'h1);
    @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1 after reset", {30'b0, out_valid, in_ready}, 32'h1);
    @(posedge clk); #1;
    // R11: no start yet, fmt_sel set to 11 but must be ignored
    send(32'h1234_5678, 0, 2'b11, "R11");
    // each mode with same-cycle start (R6), then random words
    for (int m = 0; m < 4; m++) begin
      send(32'h8001_2345 ^ 32'(m), 1, 2'(m), "R6");
      for (int k = 0; k < 6; k++) send($urandom, 0, 2'(m), "");
    end
    // R7: change fmt_sel mid-message without start
    send(32'hA5C3_0F81, 1, 2'b10, "R6");
    send(32'h0102_0304, 0, 2'b11, "R7");
    send(32'hF000_000E, 0, 2'b01, "R7");
    send(32'h0000_0001, 0, 2'b00, "R7");
    // back-pressure with random modes
    bp_en = 1;
    for (int k = 0; k < 120; k++)
      send($urandom, (k % 9) == 0, 2'($urandom_range(0, 3)), "");
    bp_en = 0;
    for (int k = 0; k < 20 && exp_q.size() != 0; k++) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R8 drained", 32'(exp_q.size()), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule